// File: doc/BRIEF.md
# DMA Request Routing Channel with Synchronization

This block is one channel of a DMA request router. A 32-bit control word picks one of 256 peripheral request lines and sends it to one DMA controller channel. In free-running mode the chosen line passes straight through to the output. In synchronized mode the output stays blocked until an edge of the chosen kind appears on one of 32 synchronization inputs. The channel then lets a programmed burst of requests through and blocks again.

A group counter counts forwarded requests. A request counts when the output request rises. When event generation is on, the channel pulses an event output for one cycle after each group completes. A synchronization edge that arrives while a burst is still open is an overrun. An overrun sets a sticky flag, which a one-cycle clear strobe resets. When its enable bit is set, the flag raises an interrupt.

Top module: `dma_req_route_chan`

## Requirements
- R1: After reset the control read-back is zero, and the request, event, overrun flag and interrupt outputs are all low.
- R2: Control word layout: line select [7:0], interrupt enable [8], event enable [9], sync-mode enable [16], edge mode [18:17], group count [23:19], sync-input select [28:24]. All other bits read back as zero.
- R3: A write to the group count field takes effect only if the stored sync-mode enable and the stored event enable are both clear. Otherwise the stored count is kept.
- R4: With sync mode off, the output request follows the selected request line in the same cycle. Lines that are not selected have no effect on it.
- R5: With event enable set, the event output is high for exactly one cycle. That cycle is the one after every (count+1)-th rising edge of the output request.
- R6: With sync mode on, no request is forwarded before the first synchronization event.
- R7: After a synchronization event, exactly count+1 requests are forwarded. The output is then blocked until the next event.
- R8: Edge mode encoding: 00 gives no event, 01 a rising edge, 10 a falling edge and 11 either edge. Edges are detected on a registered copy of the selected sync input.
- R9: A synchronization event that arrives while a burst is open sets the overrun flag. The open burst runs on to its own count+1 total without restarting.
- R10: The overrun flag stays set until the clear strobe is pulsed. After the strobe it reads low.
- R11: The interrupt output equals the overrun flag gated by the interrupt enable bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Control word write strobe |
| cfg_wdata | input | 32 | Control word write data |
| cfg_rdata | output | 32 | Control word read-back |
| flag_clr | input | 1 | Overrun flag clear strobe |
| req_lines | input | 256 | Peripheral request lines |
| sync_lines | input | 32 | Synchronization inputs |
| dma_req | output | 1 | Request to the DMA controller channel |
| evt_out | output | 1 | One-cycle group-complete event |
| ovr_flag | output | 1 | Sticky synchronization overrun flag |
| irq | output | 1 | Overrun interrupt request |

## Verification
The bench programs the count and then tries to overwrite it while an enable is set. A design that left the field unprotected would show the new count in the read-back. Each of the four edge modes is driven with a rise followed by a fall. Wrong decoding shows up as a burst forwarded on the wrong edge, or as one missing. The overrun case adds a second edge in the middle of a burst and counts how many requests get through. A design that restarted the burst on that edge would forward more than count+1 requests. The event pulse is sampled cycle by cycle, so a pulse that is late or wider than one cycle is caught.

// File: rtl/dmarc_pkg.sv
package dmarc_pkg;

    parameter int SEL_W  = 8;
    parameter int SSEL_W = 5;
    parameter int CNT_W  = 5;

    localparam int POS_SEL   = 0;
    localparam int POS_IE    = 8;
    localparam int POS_EVT   = 9;
    localparam int POS_SEN   = 16;
    localparam int POS_EDGE  = 17;
    localparam int POS_CNT   = 19;
    localparam int POS_SSEL  = 24;

    typedef enum logic [1:0] {
        EDGE_NONE = 2'b00,
        EDGE_RISE = 2'b01,
        EDGE_FALL = 2'b10,
        EDGE_BOTH = 2'b11
    } edge_mode_t;

    typedef struct packed {
        logic [SSEL_W-1:0] sync_sel;
        logic [CNT_W-1:0]  grp_cnt;
        edge_mode_t        edge_mode;
        logic              sync_en;
        logic              evt_en;
        logic              ovr_ie;
        logic [SEL_W-1:0]  line_sel;
    } chan_cfg_t;

endpackage

// File: rtl/rc_cfg_reg.sv
module rc_cfg_reg
    import dmarc_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [31:0] wdata,
    output chan_cfg_t   cfg_o,
    output logic [31:0] rdata_o
);
    chan_cfg_t cfg_d, cfg_q;
    logic      unused_bits;

    assign unused_bits = ^{wdata[15:10], wdata[31:29]};

    always_comb begin
        cfg_d = cfg_q;
        if (wr_en) begin
            cfg_d.line_sel  = wdata[POS_SEL +: SEL_W];
            cfg_d.ovr_ie    = wdata[POS_IE];
            cfg_d.evt_en    = wdata[POS_EVT];
            cfg_d.sync_en   = wdata[POS_SEN];
            cfg_d.edge_mode = edge_mode_t'(wdata[POS_EDGE +: 2]);
            cfg_d.sync_sel  = wdata[POS_SSEL +: SSEL_W];
            // the count is locked while either enable is active
            if (!cfg_q.sync_en && !cfg_q.evt_en)
                cfg_d.grp_cnt = wdata[POS_CNT +: CNT_W];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    always_comb begin
        rdata_o = '0;
        rdata_o[POS_SEL +: SEL_W]   = cfg_q.line_sel;
        rdata_o[POS_IE]             = cfg_q.ovr_ie;
        rdata_o[POS_EVT]            = cfg_q.evt_en;
        rdata_o[POS_SEN]            = cfg_q.sync_en;
        rdata_o[POS_EDGE +: 2]      = cfg_q.edge_mode;
        rdata_o[POS_CNT +: CNT_W]   = cfg_q.grp_cnt;
        rdata_o[POS_SSEL +: SSEL_W] = cfg_q.sync_sel;
    end

    assign cfg_o = cfg_q;
endmodule

// File: rtl/rc_sync_edge.sv
module rc_sync_edge
    import dmarc_pkg::*;
#(
    parameter int SW = SSEL_W,
    localparam int N = 2**SW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  sync_lines,
    input  logic [SW-1:0] sel,
    input  edge_mode_t    mode,
    output logic          sync_evt
);
    typedef struct packed {
        logic cur;
        logic prev;
    } smp_t;

    smp_t s_d, s_q;

    always_comb begin
        s_d.cur  = sync_lines[sel];
        s_d.prev = s_q.cur;
        unique case (mode)
            EDGE_RISE: sync_evt =  s_q.cur & ~s_q.prev;
            EDGE_FALL: sync_evt = ~s_q.cur &  s_q.prev;
            EDGE_BOTH: sync_evt =  s_q.cur ^  s_q.prev;
            default:   sync_evt = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end
endmodule

// File: rtl/rc_burst_ctr.sv
module rc_burst_ctr
    import dmarc_pkg::*;
#(
    parameter int CW = CNT_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_in,
    input  logic          sync_en,
    input  logic          evt_en,
    input  logic [CW-1:0] grp_cnt,
    input  logic          sync_evt,
    input  logic          flag_clr,
    output logic          req_out,
    output logic          evt_pulse,
    output logic          gate_open,
    output logic          ovr_set,
    output logic          ovr_flag
);
    typedef struct packed {
        logic          out;
        logic          open;
        logic [CW-1:0] cnt;
        logic          evt;
        logic          ovr;
    } ctr_t;

    ctr_t c_d, c_q;
    logic fwd, last, active;

    always_comb begin
        req_out = req_in & (~sync_en | c_q.open);
        fwd     = req_out & ~c_q.out;
        last    = fwd && (c_q.cnt == grp_cnt);
        active  = sync_en | evt_en;
        ovr_set = sync_en & sync_evt & c_q.open;

        c_d     = c_q;
        c_d.out = req_out;
        c_d.evt = last & evt_en;

        if (!active)     c_d.cnt = '0;
        else if (last)   c_d.cnt = '0;
        else if (fwd)    c_d.cnt = c_q.cnt + 1'b1;

        if (!sync_en)                   c_d.open = 1'b0;
        else if (sync_evt && !c_q.open) begin
            c_d.open = 1'b1;
            c_d.cnt  = '0;
        end
        else if (last)                  c_d.open = 1'b0;

        if (ovr_set)       c_d.ovr = 1'b1;
        else if (flag_clr) c_d.ovr = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign evt_pulse = c_q.evt;
    assign gate_open = c_q.open;
    assign ovr_flag  = c_q.ovr;
endmodule

// File: rtl/dma_req_route_chan.sv
module dma_req_route_chan
    import dmarc_pkg::*;
#(
    parameter int LINE_SEL_W = SEL_W,
    parameter int SYNC_SEL_W = SSEL_W,
    localparam int N_LINES = 2**LINE_SEL_W,
    localparam int N_SYNC  = 2**SYNC_SEL_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_wr,
    input  logic [31:0]        cfg_wdata,
    output logic [31:0]        cfg_rdata,
    input  logic               flag_clr,
    input  logic [N_LINES-1:0] req_lines,
    input  logic [N_SYNC-1:0]  sync_lines,
    output logic               dma_req,
    output logic               evt_out,
    output logic               ovr_flag,
    output logic               irq
);
    chan_cfg_t cfg;
    logic      sync_evt, gate_open, ovr_set, req_sel;

    rc_cfg_reg u_cfg (
        .clk(clk), .rst_n(rst_n), .wr_en(cfg_wr), .wdata(cfg_wdata),
        .cfg_o(cfg), .rdata_o(cfg_rdata)
    );

    rc_sync_edge #(.SW(SYNC_SEL_W)) u_edge (
        .clk(clk), .rst_n(rst_n), .sync_lines(sync_lines),
        .sel(cfg.sync_sel), .mode(cfg.edge_mode), .sync_evt(sync_evt)
    );

    assign req_sel = req_lines[cfg.line_sel];

    rc_burst_ctr #(.CW(CNT_W)) u_ctr (
        .clk(clk), .rst_n(rst_n), .req_in(req_sel),
        .sync_en(cfg.sync_en), .evt_en(cfg.evt_en), .grp_cnt(cfg.grp_cnt),
        .sync_evt(sync_evt), .flag_clr(flag_clr),
        .req_out(dma_req), .evt_pulse(evt_out), .gate_open(gate_open),
        .ovr_set(ovr_set), .ovr_flag(ovr_flag)
    );

    assign irq = ovr_flag & cfg.ovr_ie;
endmodule

// File: rtl/rc_chan_chk.sv
module rc_chan_chk (
    input logic clk,
    input logic rst_n,
    input logic sync_en,
    input logic gate_open,
    input logic dma_req,
    input logic evt_out,
    input logic ovr_flag,
    input logic ovr_set,
    input logic flag_clr,
    input logic irq
);
    p_evt_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        evt_out |=> !evt_out);

    p_gate_blocks_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_en && !gate_open) |-> !dma_req);

    p_ovr_midburst_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ovr_set |-> gate_open);

    p_flag_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr_flag && !flag_clr) |=> ovr_flag);

    p_flag_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_clr && !ovr_set) |=> !ovr_flag);

    p_irq_needs_flag_r11: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ovr_flag);
endmodule

bind dma_req_route_chan rc_chan_chk u_chk (
    .clk(clk), .rst_n(rst_n), .sync_en(cfg.sync_en), .gate_open(gate_open),
    .dma_req(dma_req), .evt_out(evt_out), .ovr_flag(ovr_flag),
    .ovr_set(ovr_set), .flag_clr(flag_clr), .irq(irq)
);

// File: tb/dma_req_route_chan_bench.sv
`timescale 1ns/1ps
module dma_req_route_chan_bench;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cfg_wr = 1'b0;
    logic [31:0]  cfg_wdata = '0;
    logic [31:0]  cfg_rdata;
    logic         flag_clr = 1'b0;
    logic [255:0] req_lines = '0;
    logic [31:0]  sync_lines = '0;
    logic         dma_req, evt_out, ovr_flag, irq;

    int total = 0, bad = 0;
    int seen = 0, evts = 0;
    logic prev_req = 1'b0;
    bit done = 0;

    always #10 clk = ~clk;

    dma_req_route_chan u_dma_req_route_chan (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .flag_clr(flag_clr), .req_lines(req_lines),
        .sync_lines(sync_lines), .dma_req(dma_req), .evt_out(evt_out),
        .ovr_flag(ovr_flag), .irq(irq)
    );

    always @(negedge clk) begin
        if (dma_req && !prev_req) seen++;
        if (evt_out) evts++;
        prev_req = dma_req;
    end

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(input int sel, input bit ie, input bit ev,
                                       input bit sen, input int edg, input int cnt,
                                       input int ssel);
        logic [31:0] w = '0;
        w[7:0] = sel[7:0]; w[8] = ie; w[9] = ev; w[16] = sen;
        w[18:17] = edg[1:0]; w[23:19] = cnt[4:0]; w[28:24] = ssel[4:0];
        return w;
    endfunction

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) @(posedge clk);
        #2;
    endtask

    task automatic wr_cfg(input logic [31:0] v);
        @(posedge clk); #2; cfg_wr = 1'b1; cfg_wdata = v;
        @(posedge clk); #2; cfg_wr = 1'b0;
    endtask

    task automatic pulse_req(input int line);
        @(posedge clk); #2; req_lines[line] = 1'b1;
        @(posedge clk); #2; req_lines[line] = 1'b0;
        @(posedge clk); #2;
    endtask

    task automatic zero_counts();
        @(negedge clk); seen = 0; evts = 0;
    endtask

    task automatic t_reset();
        @(negedge clk);
        check(cfg_rdata == 0, "R1 rdata", cfg_rdata, 0);
        check({dma_req, evt_out, ovr_flag, irq} == 0, "R1 outputs",
              {dma_req, evt_out, ovr_flag, irq}, 0);
    endtask

    task automatic t_fields();
        wr_cfg(32'hFFFF_FFFF); @(negedge clk);
        check(cfg_rdata == 32'h1FFF_03FF, "R2 layout all-ones", cfg_rdata, 32'h1FFF_03FF);
        wr_cfg(32'h0); @(negedge clk);
        check(cfg_rdata == 32'h00F8_0000, "R3 count kept while enabled", cfg_rdata, 32'h00F8_0000);
        wr_cfg(32'h0); @(negedge clk);
        check(cfg_rdata == 0, "R3 count written when idle", cfg_rdata, 0);
        wr_cfg(32'hEA5A_F155); @(negedge clk);
        check(cfg_rdata == 32'h0A5A_0155, "R2 layout pattern", cfg_rdata, 32'h0A5A_0155);
        wr_cfg(32'h0);
    endtask

    task automatic t_free();
        wr_cfg(32'h0);
        wr_cfg(mk(5, 0, 0, 0, 0, 0, 0));
        req_lines[5] = 1'b1; #1;
        check(dma_req == 1, "R4 selected high", dma_req, 1);
        req_lines[5] = 1'b0; req_lines[6] = 1'b1; req_lines[200] = 1'b1; #1;
        check(dma_req == 0, "R4 other lines ignored", dma_req, 0);
        wr_cfg(mk(200, 0, 0, 0, 0, 0, 0)); #1;
        check(dma_req == 1, "R4 reselect line 200", dma_req, 1);
        req_lines = '0; #1;
        check(dma_req == 0, "R4 follows low", dma_req, 0);
    endtask

    task automatic t_event();
        wr_cfg(32'h0);
        wr_cfg(mk(10, 0, 1, 0, 0, 1, 0));
        zero_counts();
        pulse_req(10);
        check(evts == 0, "R5 no event mid-group", evts, 0);
        @(posedge clk); #2; req_lines[10] = 1'b1;
        @(posedge clk); #2; req_lines[10] = 1'b0;
        @(negedge clk);
        check(evt_out == 1, "R5 event cycle after last", evt_out, 1);
        @(negedge clk);
        check(evt_out == 0, "R5 event one cycle", evt_out, 0);
        for (int i = 0; i < 4; i++) pulse_req(10);
        tick(2);
        check(seen == 6, "R5 forwarded count", seen, 6);
        check(evts == 3, "R5 events per two requests", evts, 3);
    endtask

    task automatic t_sync();
        wr_cfg(32'h0);
        wr_cfg(mk(3, 0, 1, 1, 1, 2, 7));
        zero_counts();
        for (int i = 0; i < 3; i++) pulse_req(3);
        check(seen == 0, "R6 blocked before sync", seen, 0);
        sync_lines[7] = 1'b1; tick(3);
        for (int i = 0; i < 5; i++) pulse_req(3);
        tick(2);
        check(seen == 3, "R7 burst of count+1", seen, 3);
        check(evts == 1, "R7 one group event", evts, 1);
        sync_lines[7] = 1'b0; tick(2);
    endtask

    task automatic t_edges();
        int exp_fwd [4] = '{0, 1, 1, 2};
        for (int m = 0; m < 4; m++) begin
            wr_cfg(32'h0);
            sync_lines[9] = 1'b0;
            wr_cfg(mk(20, 0, 0, 1, m, 0, 9));
            tick(3);
            zero_counts();
            sync_lines[9] = 1'b1; tick(3);
            pulse_req(20); pulse_req(20);
            sync_lines[9] = 1'b0; tick(3);
            pulse_req(20); pulse_req(20);
            tick(2);
            check(seen == exp_fwd[m], $sformatf("R8 edge mode %0d", m), seen, exp_fwd[m]);
        end
    endtask

    task automatic t_ovr();
        wr_cfg(32'h0);
        wr_cfg(mk(12, 1, 0, 1, 3, 3, 2));
        tick(2);
        zero_counts();
        sync_lines[2] = 1'b1; tick(3);
        pulse_req(12);
        @(negedge clk);
        check(ovr_flag == 0, "R9 no overrun at burst start", ovr_flag, 0);
        sync_lines[2] = 1'b0; tick(3);
        @(negedge clk);
        check(ovr_flag == 1, "R9 overrun mid-burst", ovr_flag, 1);
        check(irq == 1, "R11 irq enabled", irq, 1);
        for (int i = 0; i < 6; i++) pulse_req(12);
        tick(2);
        check(seen == 4, "R9 burst not restarted", seen, 4);
        wr_cfg(mk(12, 0, 0, 1, 3, 3, 2)); @(negedge clk);
        check(irq == 0, "R11 irq masked", irq, 0);
        tick(5); @(negedge clk);
        check(ovr_flag == 1, "R10 flag sticky", ovr_flag, 1);
        @(posedge clk); #2; flag_clr = 1'b1;
        @(posedge clk); #2; flag_clr = 1'b0;
        @(negedge clk);
        check(ovr_flag == 0, "R10 flag cleared", ovr_flag, 0);
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(2);
        t_reset();
        t_fields();
        t_free();
        t_event();
        t_sync();
        t_edges();
        t_ovr();
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule